// File: doc/BRIEF.md
# Serial Slave Pause Gate

This block sits between the pins of a serial-memory slave port and the command engine behind it. It brings the pause, clock and chip-select pins into a fast system clock through multi-stage synchronizers and finds their edges there. From these it decides when the interface is paused. While the interface is paused, the block hides serial-clock edges and incoming data from the engine and turns off the data-out driver.

A pause starts or ends at an edge of the pause pin, but only if the serial clock is low at that moment. If the clock is high at the pause edge, the change waits for the next falling clock edge. Raising chip select forces the pause off and clears any waiting change. If the interface was paused when chip select rose, the block also sends a one-cycle reset pulse to the engine.

The block has no connection to internal write, program or erase sequencing, so a pause cannot cut any of them short.

Top module: `spi_pause_gate`

## Requirements
- R1: After reset, `hold_o`, `sck_stb_o`, `eng_rst_o` and `so_oe_o` are all 0.
- R2: With chip select low (`cs_n_i`=0), a falling edge of `hold_n_i` while `sck_i` is low sets `hold_o` within 4 system cycles. This also holds when SCK falls in the same cycle as `hold_n_i`.
- R3: A falling edge of `hold_n_i` while `sck_i` is high leaves `hold_o` at 0 until the next falling edge of `sck_i`. `hold_o` is set within 4 cycles after that falling edge.
- R4: A rising edge of `hold_n_i` while `sck_i` is low clears `hold_o` within 4 system cycles.
- R5: A rising edge of `hold_n_i` while `sck_i` is high keeps `hold_o` at 1 until the next falling edge of `sck_i`, then clears it.
- R6: While `hold_o`=1, `sck_stb_o` stays 0 whatever `sck_i` does, `si_o` is 0, and `so_oe_o` is 0.
- R7: While not paused and `cs_n_i`=0, each rising edge of `sck_i` gives exactly one single-cycle pulse on `sck_stb_o`. `si_o` follows `si_i`, and `so_oe_o` follows `so_en_i`.
- R8: While `cs_n_i`=1, `hold_o`, `sck_stb_o` and `so_oe_o` are 0, and any waiting entry or exit is dropped.
- R9: A rising edge of `cs_n_i` while `hold_o`=1 gives exactly one single-cycle pulse on `eng_rst_o`. A rising edge of `cs_n_i` while not paused gives no pulse.
- R10: A falling edge of `cs_n_i` never starts a pause by itself, whatever the level of `hold_n_i`.
- R11: If `hold_n_i` falls and then rises again while `sck_i` stays high, the next falling edge of `sck_i` leaves `hold_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hold_n_i | input | 1 | Pause pin, active low, asynchronous |
| sck_i | input | 1 | Serial clock pin, asynchronous |
| cs_n_i | input | 1 | Chip select pin, active low, asynchronous |
| si_i | input | 1 | Serial data-in pin, asynchronous |
| so_en_i | input | 1 | Engine request to drive the data-out line |
| hold_o | output | 1 | Interface paused |
| sck_stb_o | output | 1 | Gated single-cycle strobe for each rising edge of SCK |
| si_o | output | 1 | Gated, synchronized data-in |
| so_oe_o | output | 1 | Gated data-out output enable |
| eng_rst_o | output | 1 | One-cycle reset to the command engine |

## Verification
Two things can happen in the same system cycle: a pause-pin edge, and a falling serial-clock edge that would complete a deferred change. The bench provokes this by driving `hold_n_i` low and `sck_i` low in the same instant, so both edges come out of the synchronizers together. The sampled SCK level is then low, so the pause must start at once (R2). No clock strobe may leak through in that cycle or afterwards. A second pairing is tested separately: chip select rising while an entry is still waiting. In that case chip select must win, and the waiting entry must not take effect at the following clock fall.

// File: rtl/spi_pause_pkg.sv
package spi_pause_pkg;
  localparam int unsigned SYNC_STAGES = 2;

  typedef struct packed {
    logic hold_n;
    logic sck;
    logic cs_n;
    logic si;
  } pin_vec_t;

  localparam int unsigned PIN_W = $bits(pin_vec_t);
  localparam pin_vec_t PIN_IDLE = '{hold_n: 1'b1, sck: 1'b0, cs_n: 1'b1, si: 1'b0};

  typedef enum logic [1:0] {
    PEND_NONE  = 2'd0,
    PEND_ENTER = 2'd1,
    PEND_EXIT  = 2'd2
  } pend_e;
endpackage

// File: rtl/spi_pause_sync.sv
module spi_pause_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_pause_dly.sv
module spi_pause_dly #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RST_VAL;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/spi_pause_ctrl.sv
module spi_pause_ctrl
  import spi_pause_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic hold_fall_i,
  input  logic hold_rise_i,
  input  logic sck_fall_i,
  input  logic cs_rise_i,
  output logic hold_o,
  output logic eng_rst_o
);
  pend_e pend_q;
  logic  hold_q, rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= PEND_NONE;
      hold_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_q <= cs_rise_i & hold_q;
      if (cs_n_i) begin
        hold_q <= 1'b0;
        pend_q <= PEND_NONE;
      end else if (hold_fall_i) begin
        if (sck_i) pend_q <= PEND_ENTER;
        else begin
          hold_q <= 1'b1;
          pend_q <= PEND_NONE;
        end
      end else if (hold_rise_i) begin
        if (sck_i) pend_q <= PEND_EXIT;
        else begin
          hold_q <= 1'b0;
          pend_q <= PEND_NONE;
        end
      end else if (sck_fall_i && pend_q != PEND_NONE) begin
        // deferred change completes on SCK fall
        hold_q <= (pend_q == PEND_ENTER);
        pend_q <= PEND_NONE;
      end
    end
  end

  assign hold_o    = hold_q;
  assign eng_rst_o = rst_q;
endmodule

// File: rtl/spi_pause_gate.sv
module spi_pause_gate
  import spi_pause_pkg::*;
#(
  parameter int unsigned STAGES = SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_n_i,
  input  logic sck_i,
  input  logic cs_n_i,
  input  logic si_i,
  input  logic so_en_i,
  output logic hold_o,
  output logic sck_stb_o,
  output logic si_o,
  output logic so_oe_o,
  output logic eng_rst_o
);
  localparam int unsigned CTL_W = PIN_W - 1;

  pin_vec_t pin_raw, pin_s;
  logic [CTL_W-1:0] ctl_s, ctl_p;
  logic hold_s, sck_s, cs_s, hold_p, sck_p, cs_p;
  logic hold_fall_w, hold_rise_w, sck_fall_w, sck_rise_w, cs_rise_w;
  logic hold_q;

  assign pin_raw = '{hold_n: hold_n_i, sck: sck_i, cs_n: cs_n_i, si: si_i};

  spi_pause_sync #(.W(PIN_W), .STAGES(STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_raw),
    .q_o   (pin_s)
  );

  assign ctl_s = {pin_s.hold_n, pin_s.sck, pin_s.cs_n};

  spi_pause_dly #(.W(CTL_W), .RST_VAL({PIN_IDLE.hold_n, PIN_IDLE.sck, PIN_IDLE.cs_n})) u_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ctl_s),
    .q_o   (ctl_p)
  );

  assign {hold_s, sck_s, cs_s} = ctl_s;
  assign {hold_p, sck_p, cs_p} = ctl_p;

  assign hold_fall_w = hold_p & ~hold_s;
  assign hold_rise_w = ~hold_p & hold_s;
  assign sck_fall_w  = sck_p & ~sck_s;
  assign sck_rise_w  = ~sck_p & sck_s;
  assign cs_rise_w   = ~cs_p & cs_s;

  spi_pause_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_n_i     (cs_s),
    .sck_i      (sck_s),
    .hold_fall_i(hold_fall_w),
    .hold_rise_i(hold_rise_w),
    .sck_fall_i (sck_fall_w),
    .cs_rise_i  (cs_rise_w),
    .hold_o     (hold_q),
    .eng_rst_o  (eng_rst_o)
  );

  assign hold_o    = hold_q;
  assign sck_stb_o = sck_rise_w & ~hold_q & ~cs_s;
  assign si_o      = pin_s.si & ~hold_q;
  assign so_oe_o   = so_en_i & ~hold_q & ~cs_s;
endmodule

// File: rtl/spi_pause_gate_chk.sv
module spi_pause_gate_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic hold_o,
  input logic sck_stb_o,
  input logic si_o,
  input logic so_oe_o,
  input logic eng_rst_o,
  input logic cs_s,
  input logic hold_fall_w,
  input logic hold_rise_w,
  input logic sck_fall_w
);
  p_no_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> !sck_stb_o);
  p_so_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> !so_oe_o);
  p_si_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> !si_o);
  p_cs_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> !hold_o);
  p_rst_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_rst_o |-> $past(hold_o));
  p_rst_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_rst_o |=> !eng_rst_o);
  p_enter_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_o) |-> $past(hold_fall_w | sck_fall_w));
  p_exit_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_o) |-> $past(hold_rise_w | sck_fall_w | cs_s));
endmodule

bind spi_pause_gate spi_pause_gate_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hold_o     (hold_o),
  .sck_stb_o  (sck_stb_o),
  .si_o       (si_o),
  .so_oe_o    (so_oe_o),
  .eng_rst_o  (eng_rst_o),
  .cs_s       (cs_s),
  .hold_fall_w(hold_fall_w),
  .hold_rise_w(hold_rise_w),
  .sck_fall_w (sck_fall_w)
);

// File: tb/spi_pause_gate_tb.sv
module spi_pause_gate_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hold_n = 1'b1, sck = 1'b0, cs_n = 1'b1, si = 1'b0, so_en = 1'b0;
  logic hold_w, stb_w, si_w, oe_w, rst_w;
  int   n_chk = 0, n_err = 0;
  int   stb_cnt = 0, rst_cnt = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  spi_pause_gate u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .hold_n_i (hold_n),
    .sck_i    (sck),
    .cs_n_i   (cs_n),
    .si_i     (si),
    .so_en_i  (so_en),
    .hold_o   (hold_w),
    .sck_stb_o(stb_w),
    .si_o     (si_w),
    .so_oe_o  (oe_w),
    .eng_rst_o(rst_w)
  );

  always @(posedge clk) begin
    if (stb_w) stb_cnt++;
    if (rst_w) rst_cnt++;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sck_pulse();
    sck = 1'b1; cyc(4);
    sck = 1'b0; cyc(4);
  endtask

  task automatic t_reset();
    chk(hold_w == 0, "R1 hold", hold_w, 0);
    chk(stb_w == 0,  "R1 strobe", stb_w, 0);
    chk(rst_w == 0,  "R1 eng_rst", rst_w, 0);
    chk(oe_w == 0,   "R1 so_oe", oe_w, 0);
  endtask

  task automatic t_stream();
    cs_n = 1'b0; so_en = 1'b1; cyc(4);
    chk(oe_w == 1, "R7 so_oe follows", oe_w, 1);
    stb_cnt = 0;
    repeat (3) sck_pulse();
    chk(stb_cnt == 3, "R7 strobe count", stb_cnt, 3);
    si = 1'b1; cyc(4);
    chk(si_w == 1, "R7 si pass", si_w, 1);
  endtask

  task automatic t_enter_low();
    hold_n = 1'b0; cyc(4);
    chk(hold_w == 1, "R2 enter sck low", hold_w, 1);
    chk(oe_w == 0, "R6 so_oe off", oe_w, 0);
    chk(si_w == 0, "R6 si masked", si_w, 0);
  endtask

  task automatic t_ignore();
    stb_cnt = 0;
    repeat (2) sck_pulse();
    chk(stb_cnt == 0, "R6 strobe blocked", stb_cnt, 0);
    chk(hold_w == 1, "R6 hold kept", hold_w, 1);
  endtask

  task automatic t_exit_low();
    hold_n = 1'b1; cyc(4);
    chk(hold_w == 0, "R4 exit sck low", hold_w, 0);
    stb_cnt = 0;
    sck_pulse();
    chk(stb_cnt == 1, "R4 strobe resumes", stb_cnt, 1);
  endtask

  task automatic t_enter_high();
    sck = 1'b1; cyc(4);
    hold_n = 1'b0; cyc(6);
    chk(hold_w == 0, "R3 deferred entry", hold_w, 0);
    stb_cnt = 0;
    sck = 1'b0; cyc(4);
    chk(hold_w == 1, "R3 entry on sck fall", hold_w, 1);
    sck = 1'b1; cyc(4);
    chk(stb_cnt == 0, "R6 rise ignored", stb_cnt, 0);
  endtask

  task automatic t_exit_high();
    hold_n = 1'b1; cyc(6);
    chk(hold_w == 1, "R5 deferred exit", hold_w, 1);
    sck = 1'b0; cyc(4);
    chk(hold_w == 0, "R5 exit on sck fall", hold_w, 0);
    stb_cnt = 0;
    sck_pulse();
    chk(stb_cnt == 1, "R5 strobe resumes", stb_cnt, 1);
  endtask

  task automatic t_cancel();
    sck = 1'b1; cyc(4);
    hold_n = 1'b0; cyc(4);
    hold_n = 1'b1; cyc(4);
    sck = 1'b0; cyc(4);
    chk(hold_w == 0, "R11 cancelled entry", hold_w, 0);
  endtask

  task automatic t_same_cycle();
    sck = 1'b1; cyc(4);
    stb_cnt = 0;
    sck = 1'b0; hold_n = 1'b0; cyc(4);
    chk(hold_w == 1, "R2 coincident edges", hold_w, 1);
    sck = 1'b1; cyc(4);
    sck = 1'b0; cyc(4);
    chk(stb_cnt == 0, "R6 no leak", stb_cnt, 0);
    hold_n = 1'b1; cyc(4);
  endtask

  task automatic t_cs_reset();
    hold_n = 1'b0; cyc(4);
    chk(hold_w == 1, "R2 enter before cs", hold_w, 1);
    rst_cnt = 0;
    cs_n = 1'b1; cyc(6);
    chk(hold_w == 0, "R8 cs clears hold", hold_w, 0);
    chk(rst_cnt == 1, "R9 one reset pulse", rst_cnt, 1);
  endtask

  task automatic t_no_reenter();
    cs_n = 1'b0; cyc(6);
    chk(hold_w == 0, "R10 no entry hold_n low", hold_w, 0);
    hold_n = 1'b1; cyc(4);
    rst_cnt = 0;
    cs_n = 1'b1; cyc(4);
    chk(rst_cnt == 0, "R9 no pulse unpaused", rst_cnt, 0);
    cs_n = 1'b0; cyc(4);
    chk(hold_w == 0, "R10 no entry hold_n high", hold_w, 0);
  endtask

  task automatic t_cs_pending();
    sck = 1'b1; cyc(4);
    hold_n = 1'b0; cyc(4);
    cs_n = 1'b1; cyc(4);
    chk(oe_w == 0, "R8 so_oe off cs high", oe_w, 0);
    cs_n = 1'b0; cyc(4);
    sck = 1'b0; cyc(4);
    chk(hold_w == 0, "R8 pending dropped", hold_w, 0);
    hold_n = 1'b1; cs_n = 1'b1; cyc(4);
    stb_cnt = 0;
    sck_pulse();
    chk(stb_cnt == 0, "R8 strobe blocked cs high", stb_cnt, 0);
  endtask

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1'b1;
    cyc(3);
    t_reset();
    t_stream();
    t_enter_low();
    t_ignore();
    t_exit_low();
    t_enter_high();
    t_exit_high();
    t_cancel();
    t_same_cycle();
    t_cs_reset();
    t_no_reenter();
    t_cs_pending();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule